// File: doc/BRIEF.md
# Level-and-Group Interrupt Arbiter

This block sits between a set of peripheral interrupt sources and a CPU. Every source owns one 8-bit control byte holding a pending flag, an enable, a 4-bit priority level and a 2-bit group rank. Among the sources that are both enabled and pending, the block finds one winner. Level is compared first. The group rank breaks ties inside a level. If level and group are both equal, the lowest source index wins.

The winner's index and level are always visible at the outputs. An interrupt request goes to the CPU only when the winner's level is strictly above the level the CPU is running at. When the CPU acknowledges, the winner's pending flag is cleared in hardware.

Software reaches the control bytes over a small byte-wide register port. It can read them back, and it can set or clear a pending flag to raise an interrupt from software.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every control byte reads 00h and irq_req is 0.
- R2: Control byte layout: bits 1:0 group rank, bits 5:2 level, bit 6 enable, bit 7 pending flag. A register write stores all eight bits, and a read at the same address returns them.
- R3: A one-cycle pulse on hw_req[i] sets the pending flag (bit 7) of source i on the next clock edge.
- R4: A source whose enable bit is 0 never wins, whatever its level.
- R5: Among candidates (enable and flag both 1), the one with the highest level wins. Level Fh is the highest and 0h the lowest.
- R6: Among candidates of equal level, the higher group rank wins, with 3 the highest.
- R7: When level and group rank are both equal, the lower source index wins.
- R8: irq_req is 1 only when the winner's level is strictly greater than cpu_level. A winner at level 0 never raises irq_req.
- R9: cpu_ack while irq_req is 1 clears the winner's pending flag. If hw_req for that same source is set in the same cycle, the flag stays 1.
- R10: Software can set a pending flag with a register write, which raises a request. It can clear the flag the same way, which withdraws the request.
- R11: irq_idx and irq_level report the winner. With no candidate they read 0 and irq_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W | Source index addressed by the register port |
| reg_wdata | input | 8 | Control byte to write |
| reg_rdata | output | 8 | Control byte of the addressed source |
| hw_req | input | NUM_SRC | Hardware request pulses, one per source |
| cpu_level | input | 4 | Priority level the CPU is currently running at |
| cpu_ack | input | 1 | CPU accepts the current request |
| irq_req | output | 1 | Request to the CPU |
| irq_idx | output | IDX_W | Index of the winning source |
| irq_level | output | 4 | Level of the winning source |

## Verification
The bench sets up contests that pit level against group rank. An arbiter that compared group before level would pick the wrong source. Another contest uses a tie in both level and group: an upper-index-first scan would report the other source. A disabled source at level Fh is set against a weak enabled source, which catches a design that ignores the enable. The CPU-level cases use equal levels and a level-0 winner, so an arbiter that compared with greater-or-equal would raise a spurious request. The acknowledge cases include one where a hardware set arrives in the same cycle. A design that let the clear win would lose that pending event.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LVL_W = 4;
  localparam int GRP_W = 2;
  localparam int KEY_W = LVL_W + GRP_W;

  // Bit order matters: software sees this as the control byte.
  typedef struct packed {
    logic             flag;
    logic             en;
    logic [LVL_W-1:0] lvl;
    logic [GRP_W-1:0] grp;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ctl_t wr_val,
  input  logic hw_set,
  input  logic ack_clr,
  output ctl_t ctl_q
);

  ctl_t ctl_r;
  ctl_t ctl_nxt;
  logic ctl_upd;

  always_comb begin
    ctl_nxt = ctl_r;
    if (wr_en) begin
      ctl_nxt = wr_val;
    end else if (ack_clr) begin
      ctl_nxt.flag = 1'b0;
    end
    // a hardware event is never lost
    if (hw_set) begin
      ctl_nxt.flag = 1'b1;
    end
  end

  assign ctl_upd = wr_en | ack_clr | hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r <= '0;
    end else if (ctl_upd) begin
      ctl_r <= ctl_nxt;
    end
  end

  assign ctl_q = ctl_r;

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  ctl_t [NUM_SRC-1:0] ctl,
  output logic               win_vld,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);

  logic [KEY_W-1:0] best_key;

  // Strictly-greater replacement keeps the lowest index on a full tie.
  always_comb begin
    best_key = '0;
    win_vld  = 1'b0;
    win_idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ctl[i].en && ctl[i].flag) begin
        if (!win_vld || ({ctl[i].lvl, ctl[i].grp} > best_key)) begin
          best_key = {ctl[i].lvl, ctl[i].grp};
          win_idx  = IDX_W'(i);
          win_vld  = 1'b1;
        end
      end
    end
    win_lvl = best_key[KEY_W-1:GRP_W];
  end

endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
  import irq_arb_pkg::*;
(
  input  logic             win_vld,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [LVL_W-1:0] cpu_level,
  output logic             req
);

  always_comb begin
    req = win_vld && (win_lvl != '0) && (win_lvl > cpu_level);
  end

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [IDX_W-1:0]   reg_addr,
  input  logic [CTL_W-1:0]   reg_wdata,
  output logic [CTL_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic [LVL_W-1:0]   cpu_level,
  input  logic               cpu_ack,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_idx,
  output logic [LVL_W-1:0]   irq_level
);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync_r;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_r <= 2'b00;
    end else begin
      rst_sync_r <= {rst_sync_r[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_r[1];

  ctl_t [NUM_SRC-1:0] ctl;
  logic [NUM_SRC-1:0] src_flag;
  logic [NUM_SRC-1:0] src_en;
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  logic               req;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic wr_hit;
    logic ack_hit;

    assign wr_hit  = reg_we && (reg_addr == IDX_W'(g));
    assign ack_hit = cpu_ack && req && (win_idx == IDX_W'(g));

    irq_src_ctrl u_src (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (wr_hit),
      .wr_val  (ctl_t'(reg_wdata)),
      .hw_set  (hw_req[g]),
      .ack_clr (ack_hit),
      .ctl_q   (ctl[g])
    );

    assign src_flag[g] = ctl[g].flag;
    assign src_en[g]   = ctl[g].en;
  end

  irq_pick #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_pick (
    .ctl     (ctl),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_cpu_gate u_gate (
    .win_vld   (win_vld),
    .win_lvl   (win_lvl),
    .cpu_level (cpu_level),
    .req       (req)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr == IDX_W'(i)) begin
        reg_rdata = ctl[i];
      end
    end
  end

  assign irq_req   = req;
  assign irq_idx   = win_idx;
  assign irq_level = win_lvl;

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [IDX_W-1:0]   reg_addr,
  input logic [NUM_SRC-1:0] hw_req,
  input logic [LVL_W-1:0]   cpu_level,
  input logic               cpu_ack,
  input logic               irq_req,
  input logic [IDX_W-1:0]   irq_idx,
  input logic [LVL_W-1:0]   irq_level,
  input logic [NUM_SRC-1:0] src_flag,
  input logic [NUM_SRC-1:0] src_en
);

  a_r8_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > cpu_level));

  a_r8_no_level0: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != '0));

  a_r4_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (src_en[irq_idx] && src_flag[irq_idx]));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_en & src_flag) == '0) |-> !irq_req);

  a_r3_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_req) |=> ((src_flag & $past(hw_req)) == $past(hw_req)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req && !hw_req[irq_idx] && !(reg_we && reg_addr == irq_idx))
      |=> !src_flag[$past(irq_idx)]);

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .NUM_SRC (NUM_SRC),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .hw_req    (hw_req),
  .cpu_level (cpu_level),
  .cpu_ack   (cpu_ack),
  .irq_req   (irq_req),
  .irq_idx   (irq_idx),
  .irq_level (irq_level),
  .src_flag  (src_flag),
  .src_en    (src_en)
);

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;

  localparam int NSRC = 8;
  localparam int IW   = 3;

  logic            clk;
  logic            rst_n;
  logic            reg_we;
  logic [IW-1:0]   reg_addr;
  logic [7:0]      reg_wdata;
  logic [7:0]      reg_rdata;
  logic [NSRC-1:0] hw_req;
  logic [3:0]      cpu_level;
  logic            cpu_ack;
  logic            irq_req;
  logic [IW-1:0]   irq_idx;
  logic [3:0]      irq_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_level_arbiter #(.NUM_SRC(NSRC)) u_irq_level_arbiter (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .hw_req (hw_req),
    .cpu_level (cpu_level), .cpu_ack (cpu_ack), .irq_req (irq_req),
    .irq_idx (irq_idx), .irq_level (irq_level)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {eight control bytes (source 7 leftmost), cpu_level, req, idx, level}
  localparam logic [75:0] VECS [0:9] = '{
    {64'h00000000_00000000, 4'h0, 1'b0, 3'd0, 4'h0},
    {64'h00000000_D5000000, 4'h0, 1'b1, 3'd3, 4'h5},
    {64'h00E40000_0000D500, 4'h0, 1'b1, 3'd6, 4'h9},
    {64'h0000DF00_00DD0000, 4'h0, 1'b1, 3'd5, 4'h7},
    {64'h000000DE_00DE0000, 4'h0, 1'b1, 3'd2, 4'h7},
    {64'hCC000000_000000BC, 4'h0, 1'b1, 3'd7, 4'h3},
    {64'h00000000_D8000000, 4'h6, 1'b0, 3'd3, 4'h6},
    {64'h00000000_D8000000, 4'h5, 1'b1, 3'd3, 4'h6},
    {64'h00000000_0000C300, 4'h0, 1'b0, 3'd1, 4'h0},
    {64'h00000000_00000050, 4'h0, 1'b0, 3'd0, 4'h0}
  };

  function automatic string vec_tag(input int k);
    case (k)
      0, 9:    return "R11";
      1, 2:    return "R5";
      3:       return "R6";
      4:       return "R7";
      5:       return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [IW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd_check(input string tag, input logic [IW-1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic out_check(input string tag, input logic r, input logic [IW-1:0] i, input logic [3:0] l);
    #1;
    check(tag, {27'h0, irq_req, irq_idx}, {27'h0, r, i});
    check(tag, {28'h0, irq_level}, {28'h0, l});
  endtask

  task automatic clear_all();
    for (int s = 0; s < NSRC; s++) wr(IW'(s), 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    hw_req = '0; cpu_level = '0; cpu_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < NSRC; s++) rd_check("R1", IW'(s), 8'h00);
    out_check("R1", 1'b0, '0, 4'h0);

    // table walk: contests, plus R2 readback of each written byte
    for (int k = 0; k < 10; k++) begin
      for (int s = 0; s < NSRC; s++) wr(IW'(s), VECS[k][12 + 8*s +: 8]);
      for (int s = 0; s < NSRC; s++) rd_check("R2", IW'(s), VECS[k][12 + 8*s +: 8]);
      cpu_level = VECS[k][11:8];
      out_check(vec_tag(k), VECS[k][7], VECS[k][6:4], VECS[k][3:0]);
    end
    cpu_level = 4'h0;
    clear_all();

    // R3: hardware pulse sets flag of source 4 (enabled, level 6)
    wr(3'd4, 8'h58);
    out_check("R3", 1'b0, 3'd0, 4'h0);
    @(negedge clk); hw_req = 8'h10;
    @(negedge clk); hw_req = '0;
    rd_check("R3", 3'd4, 8'hD8);
    out_check("R3", 1'b1, 3'd4, 4'h6);

    // R9: acknowledge clears the winner's flag
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    rd_check("R9", 3'd4, 8'h58);
    out_check("R9", 1'b0, 3'd0, 4'h0);

    // R9: hardware set in the same cycle as acknowledge wins
    wr(3'd4, 8'hD8);
    @(negedge clk); cpu_ack = 1'b1; hw_req = 8'h10;
    @(negedge clk); cpu_ack = 1'b0; hw_req = '0;
    rd_check("R9", 3'd4, 8'hD8);

    // R9: acknowledge clears only the winner; next one comes through
    wr(3'd2, 8'hCC);
    out_check("R9", 1'b1, 3'd4, 4'h6);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    rd_check("R9", 3'd2, 8'hCC);
    out_check("R9", 1'b1, 3'd2, 4'h3);
    clear_all();

    // R10: software raises and withdraws a request
    wr(3'd6, 8'hE8);
    out_check("R10", 1'b1, 3'd6, 4'hA);
    wr(3'd6, 8'h68);
    rd_check("R10", 3'd6, 8'h68);
    out_check("R10", 1'b0, 3'd0, 4'h0);

    // R8: level Fh against a CPU at Eh, then at Fh
    wr(3'd1, 8'hFC);
    cpu_level = 4'hE;
    out_check("R8", 1'b1, 3'd1, 4'hF);
    cpu_level = 4'hF;
    out_check("R8", 1'b0, 3'd1, 4'hF);

    done = 1;
    summary();
  end

endmodule